// File: doc/BRIEF.md
# Lockable System Configuration Register File

This block is a small 32-bit register slave on an APB-style bus. It holds two control words. The drive-mode word sets the fast-mode-plus drive strength of three I2C controllers and four individual pins. It also holds a firewall-disable flag that software can only clear. The reference word holds enables for the internal voltage reference, its buffers, and a two-pad output selector. It also has a lock bit that freezes the whole word until the next system reset. A read-only ready flag, fed from outside, is mirrored into the reference word.

The block takes two active-low asynchronous resets. `rst_ni` is the bus reset and clears only the drive-strength enables. `sys_rst_ni` is the system reset and returns everything to its reset value. The decoded enables go straight to the pad ring and to the analog macros.

A write is taken in the access phase (`psel_i & penable_i & pwrite_i`). Read data is valid combinationally in the same phase. There is no wait state and no error response.

Top module: `sys_cfg_regs`

## Requirements
- R1: The drive-mode word sits at byte offset 0x04 and the reference word at byte offset 0x20. Only word-aligned addresses hit a register. A write takes effect on the clock edge that ends the access phase.
- R2: The firewall-disable flag (bit 0 at 0x04, output `fw_dis_o`) is 1 after system reset. Writing 0 clears it. Writing 1 has no effect. A bus reset leaves it unchanged, and only a system reset sets it again.
- R3: Bits 14:8 at 0x04 are read/write: bits 8..11 are pin 0..3 drive enables and bits 12..14 are I2C instance 0..2 enables. Either reset clears them, so the word reads 0x0000_0001 after system reset.
- R4: Each pin drive output `pin_fmp_o[k]` is the OR of pin bit k and the I2C instance 0 enable (bit 12).
- R5: The reference word fields are read/write: bit 13 oscillator buffer, bit 12 comparator buffer, bit 9 sensor buffer, bit 8 ADC buffer, bits 5:4 pad select (00 none, 01 pad 0, 10 pad 1, 11 both), bit 0 reference enable. System reset clears them and a bus reset does not.
- R6: Writing 1 to bit 31 at 0x20 sets the lock, and the same write also updates the other fields. While the lock is 1, writes to 0x20 change nothing. Only a system reset clears the lock; a bus reset does not.
- R7: Bit 30 at 0x20 always reads the live `ref_rdy_i` input, locked or not, and writes to it are ignored.
- R8: `ref_en_o` is 1 when bit 0 or bit 9 of the reference word is 1.
- R9: Reserved bits of both words read 0 and ignore writes.
- R10: Unmapped or misaligned offsets read 0, and writes to them change no register.
- R11: `ref_pad_o[k]` is 1 only when the ADC buffer (bit 8) is on and pad-select bit 4+k is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Bus reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low, asynchronous |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| ref_rdy_i | input | 1 | Reference-ready status |
| i2c_fmp_o | output | N_I2C | Per-instance drive enables |
| pin_fmp_o | output | N_PIN | Per-pin drive enables |
| fw_dis_o | output | 1 | Firewall disabled |
| osc_buf_o | output | 1 | Oscillator reference buffer on |
| cmp_buf_o | output | 1 | Comparator reference buffer on |
| sens_buf_o | output | 1 | Sensor reference buffer on |
| adc_buf_o | output | 1 | ADC reference buffer on |
| ref_pad_o | output | 2 | Pad connections of the ADC reference |
| ref_en_o | output | 1 | Internal reference enable |
| ref_lock_o | output | 1 | Reference word locked |

## Verification
Two functions can act in the same edge. The first is the write that sets the lock while also loading new field values: the bench writes 0x8000_0101 and expects both the lock and the fields, then confirms that a later write is blocked. The second is a bus reset that falls while the firewall flag, the lock and the reference fields hold non-reset values. The bench reads both words afterwards and expects only the drive enables to have cleared. The sensor buffer forcing the reference enable is checked with bit 0 both low and high.

// File: rtl/sys_cfg_pkg.sv
`timescale 1ns/1ps
package sys_cfg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam logic [7:0]  OFF_PMODE = 8'h04;
  localparam logic [7:0]  OFF_REF   = 8'h20;

  localparam int unsigned FW_BIT    = 0;
  localparam int unsigned PMODE_LSB = 8;

  localparam int unsigned REN_BIT   = 0;
  localparam int unsigned PAD_LSB   = 4;
  localparam int unsigned PAD_W     = 2;
  localparam int unsigned ADC_BIT   = 8;
  localparam int unsigned SENS_BIT  = 9;
  localparam int unsigned CMP_BIT   = 12;
  localparam int unsigned OSC_BIT   = 13;
  localparam int unsigned RDY_BIT   = 30;
  localparam int unsigned LOCK_BIT  = 31;

  typedef struct packed {
    logic             osc_buf;
    logic             cmp_buf;
    logic             sens_buf;
    logic             adc_buf;
    logic [PAD_W-1:0] pad_sel;
    logic             ref_en;
  } ref_fields_t;
endpackage

// File: rtl/sys_cfg_bus_if.sv
`timescale 1ns/1ps
module sys_cfg_bus_if
  import sys_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [WORD_W-1:0] pmode_rd_i,
  input  logic [WORD_W-1:0] ref_rd_i,
  output logic              pmode_we_o,
  output logic              ref_we_o,
  output logic [WORD_W-1:0] prdata_o
);
  logic hit_pmode, hit_ref, wr_acc;

  assign hit_pmode = (paddr_i == ADDR_W'(OFF_PMODE));
  assign hit_ref   = (paddr_i == ADDR_W'(OFF_REF));
  assign wr_acc    = psel_i & penable_i & pwrite_i;

  assign pmode_we_o = wr_acc & hit_pmode;
  assign ref_we_o   = wr_acc & hit_ref;

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      if (hit_pmode)    prdata_o = pmode_rd_i;
      else if (hit_ref) prdata_o = ref_rd_i;
    end
  end
endmodule

// File: rtl/sys_cfg_pmode_reg.sv
`timescale 1ns/1ps
module sys_cfg_pmode_reg
  import sys_cfg_pkg::*;
#(
  parameter int unsigned N_PIN = 4,
  parameter int unsigned N_I2C = 3
) (
  input  logic              clk_i,
  input  logic              drv_rst_ni,
  input  logic              sys_rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rd_o,
  output logic [N_I2C-1:0]  i2c_o,
  output logic [N_PIN-1:0]  pin_o,
  output logic              fw_dis_o
);
  localparam int unsigned FIELD_W = N_PIN + N_I2C;

  logic [FIELD_W-1:0] drv_q;
  logic               fw_q;

  always_ff @(posedge clk_i or negedge drv_rst_ni) begin
    if (!drv_rst_ni)  drv_q <= '0;
    else if (we_i)    drv_q <= wdata_i[PMODE_LSB +: FIELD_W];
  end

  // sticky clear: only system reset sets it again
  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni)                    fw_q <= 1'b1;
    else if (we_i && !wdata_i[FW_BIT])  fw_q <= 1'b0;
  end

  always_comb begin
    rd_o                        = '0;
    rd_o[PMODE_LSB +: FIELD_W]  = drv_q;
    rd_o[FW_BIT]                = fw_q;
  end

  assign i2c_o    = drv_q[N_PIN +: N_I2C];
  assign fw_dis_o = fw_q;

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    assign pin_o[g] = drv_q[g] | i2c_o[0];
  end

  a_r2_fw_never_sets: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    !fw_q |=> !fw_q);
  a_r4_i2c0_drives_pins: assert property (@(posedge clk_i) disable iff (!drv_rst_ni)
    i2c_o[0] |-> (&pin_o));
  a_r3_bus_reset_clears: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    $rose(drv_rst_ni) |-> (drv_q == '0));
endmodule

// File: rtl/sys_cfg_ref_reg.sv
`timescale 1ns/1ps
module sys_cfg_ref_reg
  import sys_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              sys_rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rdy_i,
  output logic [WORD_W-1:0] rd_o,
  output ref_fields_t       fld_o,
  output logic [PAD_W-1:0]  pad_o,
  output logic              ref_en_o,
  output logic              lock_o
);
  ref_fields_t f_q, f_d;
  logic        lock_q;

  always_comb begin
    f_d.osc_buf  = wdata_i[OSC_BIT];
    f_d.cmp_buf  = wdata_i[CMP_BIT];
    f_d.sens_buf = wdata_i[SENS_BIT];
    f_d.adc_buf  = wdata_i[ADC_BIT];
    f_d.pad_sel  = wdata_i[PAD_LSB +: PAD_W];
    f_d.ref_en   = wdata_i[REN_BIT];
  end

  // lock and fields load together; the lock gates later writes
  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni) begin
      f_q    <= '0;
      lock_q <= 1'b0;
    end else if (we_i && !lock_q) begin
      f_q    <= f_d;
      lock_q <= wdata_i[LOCK_BIT];
    end
  end

  always_comb begin
    rd_o                     = '0;
    rd_o[LOCK_BIT]           = lock_q;
    rd_o[RDY_BIT]            = rdy_i;
    rd_o[OSC_BIT]            = f_q.osc_buf;
    rd_o[CMP_BIT]            = f_q.cmp_buf;
    rd_o[SENS_BIT]           = f_q.sens_buf;
    rd_o[ADC_BIT]            = f_q.adc_buf;
    rd_o[PAD_LSB +: PAD_W]   = f_q.pad_sel;
    rd_o[REN_BIT]            = f_q.ref_en;
  end

  for (genvar k = 0; k < PAD_W; k++) begin : g_pad
    assign pad_o[k] = f_q.adc_buf & f_q.pad_sel[k];
  end

  assign fld_o    = f_q;
  assign ref_en_o = f_q.ref_en | f_q.sens_buf;
  assign lock_o   = lock_q;

  a_r6_lock_freezes: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    lock_q |=> (lock_q && $stable(f_q)));
  a_r8_sensor_forces_ref: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    f_q.sens_buf |-> ref_en_o);
  a_r11_pad_needs_adc: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    (|pad_o) |-> f_q.adc_buf);
endmodule

// File: rtl/sys_cfg_regs.sv
`timescale 1ns/1ps
module sys_cfg_regs
  import sys_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_PIN  = 4,
  parameter int unsigned N_I2C  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  input  logic              ref_rdy_i,
  output logic [N_I2C-1:0]  i2c_fmp_o,
  output logic [N_PIN-1:0]  pin_fmp_o,
  output logic              fw_dis_o,
  output logic              osc_buf_o,
  output logic              cmp_buf_o,
  output logic              sens_buf_o,
  output logic              adc_buf_o,
  output logic [1:0]        ref_pad_o,
  output logic              ref_en_o,
  output logic              ref_lock_o
);
  logic [WORD_W-1:0] pmode_rd, ref_rd;
  logic              pmode_we, ref_we;
  logic              drv_rst_n;
  ref_fields_t       ref_fld;

  // drive enables fall on either reset
  assign drv_rst_n = rst_ni & sys_rst_ni;

  sys_cfg_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .paddr_i    (paddr_i),
    .pmode_rd_i (pmode_rd),
    .ref_rd_i   (ref_rd),
    .pmode_we_o (pmode_we),
    .ref_we_o   (ref_we),
    .prdata_o   (prdata_o)
  );

  sys_cfg_pmode_reg #(.N_PIN(N_PIN), .N_I2C(N_I2C)) u_pmode (
    .clk_i      (clk_i),
    .drv_rst_ni (drv_rst_n),
    .sys_rst_ni (sys_rst_ni),
    .we_i       (pmode_we),
    .wdata_i    (pwdata_i),
    .rd_o       (pmode_rd),
    .i2c_o      (i2c_fmp_o),
    .pin_o      (pin_fmp_o),
    .fw_dis_o   (fw_dis_o)
  );

  sys_cfg_ref_reg u_ref (
    .clk_i      (clk_i),
    .sys_rst_ni (sys_rst_ni),
    .we_i       (ref_we),
    .wdata_i    (pwdata_i),
    .rdy_i      (ref_rdy_i),
    .rd_o       (ref_rd),
    .fld_o      (ref_fld),
    .pad_o      (ref_pad_o),
    .ref_en_o   (ref_en_o),
    .lock_o     (ref_lock_o)
  );

  assign osc_buf_o  = ref_fld.osc_buf;
  assign cmp_buf_o  = ref_fld.cmp_buf;
  assign sens_buf_o = ref_fld.sens_buf;
  assign adc_buf_o  = ref_fld.adc_buf;

  a_r10_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    (psel_i && paddr_i != ADDR_W'(OFF_PMODE) && paddr_i != ADDR_W'(OFF_REF)) |-> (prdata_o == '0));
  a_r9_reserved_ref_zero: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    (psel_i && !pwrite_i && paddr_i == ADDR_W'(OFF_REF)) |->
      (prdata_o[29:14] == '0 && prdata_o[11:10] == '0 && prdata_o[7:6] == '0 && prdata_o[3:1] == '0));
  a_r7_ready_mirrors: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    (psel_i && !pwrite_i && paddr_i == ADDR_W'(OFF_REF)) |-> (prdata_o[30] == ref_rdy_i));
endmodule

// File: tb/sys_cfg_regs_bench.sv
`timescale 1ns/1ps
module sys_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, sys_rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        ref_rdy = 1'b0;
  logic [2:0]  i2c_fmp;
  logic [3:0]  pin_fmp;
  logic        fw_dis, osc_buf, cmp_buf, sens_buf, adc_buf, ref_en, ref_lock;
  logic [1:0]  ref_pad;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  sys_cfg_regs u_sys_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .ref_rdy_i(ref_rdy), .i2c_fmp_o(i2c_fmp), .pin_fmp_o(pin_fmp),
    .fw_dis_o(fw_dis), .osc_buf_o(osc_buf), .cmp_buf_o(cmp_buf),
    .sens_buf_o(sens_buf), .adc_buf_o(adc_buf), .ref_pad_o(ref_pad),
    .ref_en_o(ref_en), .ref_lock_o(ref_lock)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // driver: queue the expectation, then run the read access
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  // monitor: compare read data one step after the completing edge
  initial forever begin
    @(posedge clk); #1;
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1: unexpected read, actual 0x%08h expected none", prdata);
      end else begin
        chk(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic outs(input string tag, input logic [3:0] pins, input logic [2:0] i2c,
                      input logic fw, input logic en, input logic [1:0] pad, input logic lk);
    chk({tag, " pins"}, 32'(pin_fmp), 32'(pins));
    chk({tag, " i2c"},  32'(i2c_fmp), 32'(i2c));
    chk({tag, " fw"},   32'(fw_dis),  32'(fw));
    chk({tag, " ref_en"}, 32'(ref_en), 32'(en));
    chk({tag, " pad"},  32'(ref_pad), 32'(pad));
    chk({tag, " lock"}, 32'(ref_lock), 32'(lk));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);
    outs("R2 R3 reset", 4'h0, 3'h0, 1'b1, 1'b0, 2'b00, 1'b0);
    rd(8'h04, 32'h0000_0001, "R3 reset value");
    rd(8'h20, 32'h0000_0000, "R5 reset value");

    ref_rdy = 1'b1;
    rd(8'h20, 32'h4000_0000, "R7 ready mirrored");
    wr(8'h20, 32'h4000_0000);
    ref_rdy = 1'b0;
    rd(8'h20, 32'h0000_0000, "R7 ready not writable");
    ref_rdy = 1'b1;

    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_7F01, "R3 R9 all enables, reserved zero, fw kept by write 1");
    outs("R3", 4'hF, 3'h7, 1'b1, 1'b0, 2'b00, 1'b0);
    wr(8'h04, 32'h0000_0501);
    outs("R4 pins only", 4'b0101, 3'h0, 1'b1, 1'b0, 2'b00, 1'b0);
    wr(8'h04, 32'h0000_1501);
    outs("R4 i2c0 ORed", 4'hF, 3'h1, 1'b1, 1'b0, 2'b00, 1'b0);
    wr(8'h04, 32'h0000_2001);
    outs("R4 i2c1 no OR", 4'h0, 3'h2, 1'b1, 1'b0, 2'b00, 1'b0);

    wr(8'h04, 32'h0000_0000);
    chk("R2 cleared", 32'(fw_dis), 32'h0);
    wr(8'h04, 32'h0000_0001);
    chk("R2 cannot set", 32'(fw_dis), 32'h0);
    rd(8'h04, 32'h0000_0000, "R2 read after set attempt");

    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0, "R10 unmapped read");
    rd(8'h21, 32'h0, "R10 misaligned read");
    rd(8'h04, 32'h0, "R10 pmode untouched");
    rd(8'h20, 32'h4000_0000, "R10 ref untouched");
    outs("R10", 4'h0, 3'h0, 1'b0, 1'b0, 2'b00, 1'b0);

    wr(8'h20, 32'h0000_3331);
    rd(8'h20, 32'h4000_3331, "R5 all fields");
    chk("R5 osc", 32'(osc_buf), 32'h1);
    chk("R5 cmp", 32'(cmp_buf), 32'h1);
    chk("R5 sens", 32'(sens_buf), 32'h1);
    chk("R5 adc", 32'(adc_buf), 32'h1);
    outs("R11 both pads", 4'h0, 3'h0, 1'b0, 1'b1, 2'b11, 1'b0);
    wr(8'h20, 32'h0000_0210);
    outs("R8 sensor forces ref, R11 no adc", 4'h0, 3'h0, 1'b0, 1'b1, 2'b00, 1'b0);
    wr(8'h20, 32'h0000_0120);
    outs("R8 ref off, R11 pad1", 4'h0, 3'h0, 1'b0, 1'b0, 2'b10, 1'b0);
    wr(8'h20, 32'h0000_0111);
    outs("R11 pad0", 4'h0, 3'h0, 1'b0, 1'b1, 2'b01, 1'b0);
    wr(8'h20, 32'h7FFF_FFFE);
    rd(8'h20, 32'h4000_3330, "R9 ref reserved ignored");

    wr(8'h04, 32'h0000_7F00);
    rd(8'h04, 32'h0000_7F00, "R3 enables before bus reset");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(8'h04, 32'h0000_0000, "R3 R2 bus reset clears enables, fw stays clear");
    rd(8'h20, 32'h4000_3330, "R5 bus reset keeps ref");

    wr(8'h20, 32'h8000_0101);
    rd(8'h20, 32'hC000_0101, "R6 lock and fields in one write");
    outs("R6 locked", 4'h0, 3'h0, 1'b0, 1'b1, 2'b00, 1'b1);
    wr(8'h20, 32'h0000_3330);
    rd(8'h20, 32'hC000_0101, "R6 write blocked");
    ref_rdy = 1'b0;
    rd(8'h20, 32'h8000_0101, "R7 ready live while locked");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(8'h20, 32'h8000_0101, "R6 lock survives bus reset");

    @(negedge clk); rst_n = 1'b0; sys_rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1; sys_rst_n = 1'b1;
    rd(8'h20, 32'h0000_0000, "R6 system reset unlocks");
    rd(8'h04, 32'h0000_0001, "R2 system reset sets fw");
    wr(8'h20, 32'h0000_0010);
    rd(8'h20, 32'h0000_0010, "R6 writable after unlock");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule